// File: doc/BRIEF.md
# Transmit Power Level Bar

This block periodically reads a transmit power detector through an external 12-bit serial ADC and shows the result on a five-segment LED bar. Each conversion is a single SPI transaction in mode 0. The block sends a command word that selects the ADC input channel and, in the same frame, shifts in the converted value. The newest reading is kept on an output port so that a host link can forward it. The bar segments are lit from a ladder of thresholds that roughly doubles from one step to the next.

A separate status LED blinks at all times. Its toggle period is set by the push-to-talk input: a slow blink while receiving and a fast blink while transmitting. All inputs are taken as synchronous to `clk`. Reset is synchronous and active high.

Top module: `pwrbar_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `adc_cs_n` is 1, `adc_sclk` is 0, `level_led` is 0 and `power_sample` is 0.
- R2: Each transaction holds `adc_cs_n` low for exactly 16 rising edges of `adc_sclk`. `adc_sclk` idles low and is never high while `adc_cs_n` is high.
- R3: `adc_mosi` is stable at each rising `adc_sclk` edge and carries, MSB first, the 16-bit word `{2'b00, ADC_CH[2:0], 11'b0}`.
- R4: `adc_miso` is sampled on rising `adc_sclk` edges. The 4 leading bits are discarded and the next 12 bits form the sample, MSB first. `power_sample` takes this value on the clock edge where `adc_cs_n` returns high.
- R5: `level_led[k]` is 1 exactly when the sample is strictly greater than the threshold for bit k. The thresholds are 250, 500, 1000, 2000 and 3000 for bits 0 to 4. A sample equal to a threshold leaves that bit off, so the bar always forms a thermometer code.
- R6: `level_led` changes as a single word, one clock after `power_sample` changes, and always reflects the registered sample.
- R7: Transactions start every 2^POLL_LOG2 clocks, so consecutive falling edges of `adc_cs_n` are exactly 2^POLL_LOG2 cycles apart.
- R8: With `ptt` low, `status_led` toggles every 2^SLOW_LOG2 clocks.
- R9: With `ptt` high, `status_led` toggles every 2^FAST_LOG2 clocks.
- R10: `power_sample` holds its value between updates and does not change while `adc_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_miso | input | 1 | Serial data from the ADC |
| ptt | input | 1 | Push-to-talk state, high while transmitting |
| adc_sclk | output | 1 | SPI serial clock, idles low |
| adc_cs_n | output | 1 | ADC chip select, active low |
| adc_mosi | output | 1 | Serial command to the ADC (channel select) |
| level_led | output | 5 | Power bar segments, bit 0 is the lowest level |
| status_led | output | 1 | Blinking status indicator |
| power_sample | output | 12 | Most recent ADC reading |

## Verification
The bench feeds each threshold and the value just above it, together with zero, full scale and a mixed bit pattern. An off-by-one comparator lights a segment at exactly 250 or 3000, and a wrong bit order or a lost lead-in bit returns a scrambled sample. The bench counts `adc_sclk` edges per frame and captures the command word, so a frame that is one bit short or long, or a misplaced channel field, shows up directly. It also measures the spacing between polls and the blink periods in both push-to-talk states, where an off-by-one terminal count or swapped rates changes the measured interval.

// File: rtl/pwrbar_pkg.sv
package pwrbar_pkg;

    localparam int SMP_W   = 12;
    localparam int FRAME_W = 16;
    localparam int LEAD_W  = FRAME_W - SMP_W;
    localparam int NUM_LVL = 5;
    localparam int CH_W    = 3;

    typedef logic [SMP_W-1:0]   sample_t;
    typedef logic [NUM_LVL-1:0] bar_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_SHIFT,
        XF_CLOSE
    } xfer_state_e;

    // Threshold ladder, lowest segment first.
    function automatic sample_t lvl_threshold(input int idx);
        sample_t t;
        case (idx)
            0:       t = sample_t'(250);
            1:       t = sample_t'(500);
            2:       t = sample_t'(1000);
            3:       t = sample_t'(2000);
            default: t = sample_t'(3000);
        endcase
        return t;
    endfunction

    // Strict greater-than against every rung.
    function automatic bar_t bar_of(input sample_t s);
        bar_t b;
        for (int i = 0; i < NUM_LVL; i++) begin
            b[i] = (s > lvl_threshold(i));
        end
        return b;
    endfunction

    // Command word: two zero bits, channel address, zero fill.
    function automatic frame_t cmd_word(input logic [CH_W-1:0] ch);
        return {2'b00, ch, {(FRAME_W-2-CH_W){1'b0}}};
    endfunction

endpackage

// File: rtl/pwrbar_spi_rd.sv
module pwrbar_spi_rd
    import pwrbar_pkg::*;
#(
    parameter int             SCLK_HALF = 4,
    parameter logic [CH_W-1:0] ADC_CH   = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    miso,
    output logic    sclk,
    output logic    cs_n,
    output logic    mosi,
    output sample_t sample,
    output logic    done,
    output logic    busy
);
    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);
    localparam frame_t CMD = cmd_word(ADC_CH);

    xfer_state_e       state;
    logic [DIV_W-1:0]  div;
    logic [BIT_W-1:0]  bitn;
    sample_t           shreg;
    frame_t            cmd_sh;

    assign mosi = cmd_sh[FRAME_W-1];
    assign busy = (state != XF_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XF_IDLE;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            div    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            cmd_sh <= '0;
            sample <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                XF_IDLE: begin
                    if (start) begin
                        state  <= XF_SHIFT;
                        cs_n   <= 1'b0;
                        cmd_sh <= CMD;
                        div    <= '0;
                        bitn   <= '0;
                    end
                end
                XF_SHIFT: begin
                    if (div == DIV_LAST) begin
                        div <= '0;
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            shreg <= {shreg[SMP_W-2:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bitn == BIT_LAST) begin
                                state <= XF_CLOSE;
                            end else begin
                                bitn   <= bitn + 1'b1;
                                cmd_sh <= {cmd_sh[FRAME_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                XF_CLOSE: begin
                    cs_n   <= 1'b1;
                    cmd_sh <= '0;
                    sample <= shreg;
                    done   <= 1'b1;
                    state  <= XF_IDLE;
                end
                default: state <= XF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwrbar_bar_map.sv
module pwrbar_bar_map
    import pwrbar_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sample_t sample,
    output bar_t    leds
);
    always_ff @(posedge clk) begin
        if (rst) begin
            leds <= '0;
        end else if (load) begin
            leds <= bar_of(sample);
        end
    end
endmodule

// File: rtl/pwrbar_blinker.sv
module pwrbar_blinker #(
    parameter int SLOW_LOG2 = 24,
    parameter int FAST_LOG2 = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic ptt,
    output logic led
);
    localparam int W = SLOW_LOG2;
    localparam logic [W-1:0] SLOW_LIM = {W{1'b1}};
    localparam logic [W-1:0] FAST_LIM = {W{1'b1}} >> (SLOW_LOG2 - FAST_LOG2);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim = ptt ? FAST_LIM : SLOW_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            led <= 1'b0;
        end else if (cnt >= lim) begin
            cnt <= '0;
            led <= ~led;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwrbar_top.sv
module pwrbar_top
    import pwrbar_pkg::*;
#(
    parameter int              POLL_LOG2 = 16,
    parameter int              SLOW_LOG2 = 24,
    parameter int              FAST_LOG2 = 22,
    parameter int              SCLK_HALF = 4,
    parameter logic [CH_W-1:0] ADC_CH    = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adc_miso,
    input  logic        ptt,
    output logic        adc_sclk,
    output logic        adc_cs_n,
    output logic        adc_mosi,
    output logic [4:0]  level_led,
    output logic        status_led,
    output logic [11:0] power_sample
);
    logic [POLL_LOG2-1:0] poll_cnt;
    logic    poll_go;
    logic    xf_busy;
    logic    xf_done;
    sample_t smp;
    bar_t    bar;

    assign poll_go = (poll_cnt == {POLL_LOG2{1'b1}}) && !xf_busy;

    always_ff @(posedge clk) begin
        if (rst) poll_cnt <= '0;
        else     poll_cnt <= poll_cnt + 1'b1;
    end

    pwrbar_spi_rd #(
        .SCLK_HALF (SCLK_HALF),
        .ADC_CH    (ADC_CH)
    ) u_spi (
        .clk    (clk),
        .rst    (rst),
        .start  (poll_go),
        .miso   (adc_miso),
        .sclk   (adc_sclk),
        .cs_n   (adc_cs_n),
        .mosi   (adc_mosi),
        .sample (smp),
        .done   (xf_done),
        .busy   (xf_busy)
    );

    pwrbar_bar_map u_map (
        .clk    (clk),
        .rst    (rst),
        .load   (xf_done),
        .sample (smp),
        .leds   (bar)
    );

    pwrbar_blinker #(
        .SLOW_LOG2 (SLOW_LOG2),
        .FAST_LOG2 (FAST_LOG2)
    ) u_blink (
        .clk (clk),
        .rst (rst),
        .ptt (ptt),
        .led (status_led)
    );

    assign level_led    = bar;
    assign power_sample = smp;
endmodule

// File: rtl/pwrbar_chk.sv
module pwrbar_chk
    import pwrbar_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    cs_n,
    input logic    sclk,
    input bar_t    leds,
    input sample_t sample
);
    // R1: clean state right after reset release
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cs_n && !sclk && leds == '0 && sample == '0));

    // R2: serial clock only runs inside a frame
    p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R5: bar is always a thermometer code
    p_bar_thermo_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot({1'b0, leds} + 6'd1));

    // R6: bar follows the registered sample one clock later
    p_bar_tracks_r6: assert property (@(posedge clk) disable iff (rst)
        leds == bar_of($past(sample)));

    // R10: sample frozen during a frame
    p_sample_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(sample));
endmodule

bind pwrbar_top pwrbar_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (adc_cs_n),
    .sclk   (adc_sclk),
    .leds   (level_led),
    .sample (power_sample)
);

// File: tb/tb_pwrbar_top.sv
module tb_pwrbar_top;
    localparam int POLL_LOG2 = 8;
    localparam int SLOW_LOG2 = 10;
    localparam int FAST_LOG2 = 8;
    localparam logic [2:0] CH = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ptt = 1'b0;
    logic miso = 1'b0;
    logic sclk, cs_n, mosi, status;
    logic [4:0]  leds;
    logic [11:0] sample;

    always #4 clk = ~clk;

    pwrbar_top #(
        .POLL_LOG2 (POLL_LOG2),
        .SLOW_LOG2 (SLOW_LOG2),
        .FAST_LOG2 (FAST_LOG2),
        .SCLK_HALF (2),
        .ADC_CH    (CH)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .adc_miso     (miso),
        .ptt          (ptt),
        .adc_sclk     (sclk),
        .adc_cs_n     (cs_n),
        .adc_mosi     (mosi),
        .level_led    (leds),
        .status_led   (status),
        .power_sample (sample)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_bar(input int v);
        return {v > 3000, v > 2000, v > 1000, v > 500, v > 250};
    endfunction

    // Behavioural ADC: four zero lead bits then the 12-bit value, MSB first.
    logic [11:0] adc_val = '0;
    logic [15:0] adc_word = '0;
    bit in_frame = 1'b0;
    always @(negedge cs_n or posedge cs_n or negedge sclk) begin
        if (cs_n) begin
            in_frame = 1'b0;
        end else if (!in_frame) begin
            in_frame = 1'b1;
            adc_word = {4'b0000, adc_val};
            miso     = adc_word[15];
        end else begin
            adc_word = adc_word << 1;
            miso     = adc_word[15];
        end
    end

    int rise_cnt = 0;
    logic [15:0] mosi_cap = '0;
    always @(negedge cs_n or posedge sclk) begin
        if (sclk) begin
            rise_cnt++;
            mosi_cap = {mosi_cap[14:0], mosi};
        end else begin
            rise_cnt = 0;
            mosi_cap = '0;
        end
    end

    // Scoreboard
    int exp_q[$];
    int last_exp = 0;

    initial begin
        forever begin
            @(posedge cs_n);
            if (!rst) begin
                int e;
                @(negedge clk);
                check(leds == exp_bar(last_exp), "R6 bar not yet updated", leds, exp_bar(last_exp));
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    e = last_exp;
                end else begin
                    e = exp_q.pop_front();
                end
                check(sample == 12'(e), "R4 sample value", sample, e);
                check(leds == exp_bar(e), "R5 bar segments", leds, exp_bar(e));
                check(rise_cnt == 16, "R2 sclk edges per frame", rise_cnt, 16);
                check(mosi_cap == {2'b00, CH, 11'b0}, "R3 command word", mosi_cap, {2'b00, CH, 11'b0});
                last_exp = e;
            end
        end
    end

    // Poll spacing and sample hold
    longint last_fall = -1;
    initial begin
        forever begin
            @(negedge cs_n);
            if (!rst) begin
                if (last_fall >= 0)
                    check(cyc - last_fall == (1 << POLL_LOG2), "R7 poll spacing",
                          int'(cyc - last_fall), 1 << POLL_LOG2);
                check(sample == 12'(last_exp), "R10 sample held", sample, last_exp);
                last_fall = cyc;
            end
        end
    end

    task automatic measure_toggle(output int n);
        logic prev;
        @(negedge clk);
        prev = status;
        while (status == prev) @(negedge clk);
        prev = status;
        n = 0;
        while (status == prev) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    int vals[13] = '{0, 250, 251, 500, 501, 1000, 1001, 2000, 2001, 3000, 3001, 4095, 2652};

    initial begin
        int per;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        check(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        check(leds == 5'd0, "R1 bar in reset", leds, 0);
        check(sample == 12'd0, "R1 sample in reset", sample, 0);
        rst = 1'b0;

        foreach (vals[i]) begin
            adc_val = 12'(vals[i]);
            exp_q.push_back(vals[i]);
            @(posedge cs_n);
        end
        repeat (10) @(negedge clk);

        measure_toggle(per);
        check(per == (1 << SLOW_LOG2), "R8 slow blink period", per, 1 << SLOW_LOG2);
        ptt = 1'b1;
        measure_toggle(per);
        check(per == (1 << FAST_LOG2), "R9 fast blink period", per, 1 << FAST_LOG2);
        measure_toggle(per);
        check(per == (1 << FAST_LOG2), "R9 fast blink repeat", per, 1 << FAST_LOG2);
        ptt = 1'b0;
        measure_toggle(per);
        check(per == (1 << SLOW_LOG2), "R8 slow blink after release", per, 1 << SLOW_LOG2);

        finish_run();
    end
endmodule